// File: doc/BRIEF.md
# Link-Down Periodic Logic Reset Watchdog

This block supervises a PHY datapath whose link can get stuck down. While the link-up status is low and no loopback is in effect, it measures a full interval of consecutive down cycles. When that interval expires, it emits a one-cycle request that sets the PHY's self-clearing logic-reset command bit. This reset keeps the configuration registers intact. The watchdog then waits for that bit to read back as clear.

The wait is a bounded poll. The block samples the reset-done indication once every poll period, for a limited number of polls. If no poll sees the indication, the block raises a sticky timeout flag, which software clears with a write-one strobe. In both cases the interval timer then starts again from zero, so a link that stays down gets a fresh reset once per interval. At the defaults (125 MHz clock) the interval is 5 s, the poll period is 1 µs and there are 50 polls.

Top module: `link_reset_watchdog`

## Requirements
- R1: With link_up low and loopback_active low on INTERVAL_CYCLES consecutive clock edges (the timer starting from zero), logic_rst_pulse is high for exactly one cycle, in the cycle after the last of those edges.
- R2: A clock edge that samples link_up high returns the interval timer to zero, so the next request needs a further INTERVAL_CYCLES down edges.
- R3: While loopback_active is high, no request is issued and the timer is held at zero, whatever link_up is.
- R4: After each handshake ends, the interval timer restarts from zero. With the link held down, successive requests are therefore 1 + j*POLL_CYCLES + INTERVAL_CYCLES cycles apart, where j is the number of polls that handshake used.
- R5: After a request, rst_done is sampled only at the poll instants, which fall POLL_CYCLES cycles apart starting POLL_CYCLES cycles after the handshake begins. The first poll that sees it high ends the handshake. A level that is high only between poll instants is not seen.
- R6: If none of the MAX_POLLS polls sees rst_done high, timeout_flag is set as the handshake ends, and interval timing resumes.
- R7: timeout_flag stays set until an edge samples tmo_clr high. If a new timeout and tmo_clr arrive on the same edge, the flag ends up set.
- R8: link_up rising during a handshake does not abort it. The polls and any timeout still happen.
- R9: While rst is high, logic_rst_pulse and timeout_flag are low and the interval timer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link-up status from the PHY |
| loopback_active | input | 1 | High while any loopback mode is in use |
| rst_done | input | 1 | High when the self-clearing reset bit reads back as clear |
| tmo_clr | input | 1 | Write-one strobe that clears the timeout flag |
| logic_rst_pulse | output | 1 | One-cycle request that sets the logic-reset command bit |
| timeout_flag | output | 1 | Sticky flag: a reset handshake ran out of polls |

## Verification
The main sweep moves the responder's delay from zero up past the last poll instant, one cycle per step. Each step measures the gap between two successive requests and checks the timeout flag. A poll that is one cycle early or late, an off-by-one in the poll count, or a timer that fails to restart shows up as a gap that differs from the arithmetic expectation. Separate patterns then check:
- a single up cycle just before expiry, which separates a restart from a pause;
- a long loopback period with the link down;
- link-up arriving during a handshake that must still time out;
- a clear strobe held across the timeout edge, which shows that setting wins over clearing.

// File: rtl/lrw_pkg.sv
package lrw_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_WAIT = 1'b1
  } hs_state_t;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lrw_interval_timer.sv
module lrw_interval_timer #(
  parameter int INTERVAL_CYCLES = 625_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic busy,
  output logic fire
);
  localparam int CW = lrw_pkg::bits_for(INTERVAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  // Counts consecutive down edges; the cycle of its own request and the
  // whole handshake keep it at zero so timing restarts afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (hold || busy || fire) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt  <= '0;
        fire <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lrw_reset_handshake.sv
module lrw_reset_handshake #(
  parameter int POLL_CYCLES = 125,
  parameter int MAX_POLLS   = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  input  logic clr,
  output logic busy,
  output logic timeout
);
  import lrw_pkg::*;

  localparam int PW = bits_for(POLL_CYCLES);
  localparam int NW = bits_for(MAX_POLLS);
  localparam logic [PW-1:0] PLAST = PW'(POLL_CYCLES - 1);
  localparam logic [NW-1:0] NLAST = NW'(MAX_POLLS - 1);

  hs_state_t     state;
  logic [PW-1:0] ptmr;
  logic [NW-1:0] polls;
  logic          poll_now;
  logic          give_up;

  assign poll_now = (state == HS_WAIT) && (ptmr == PLAST);
  assign give_up  = poll_now && !done && (polls == NLAST);
  assign busy     = (state == HS_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_IDLE;
      ptmr  <= '0;
      polls <= '0;
    end else begin
      case (state)
        HS_IDLE: begin
          ptmr  <= '0;
          polls <= '0;
          if (start) state <= HS_WAIT;
        end
        HS_WAIT: begin
          if (poll_now) begin
            ptmr <= '0;
            if (done || give_up) state <= HS_IDLE;
            else                 polls <= polls + 1'b1;
          end else begin
            ptmr <= ptmr + 1'b1;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  // Sticky flag: a new timeout takes priority over a clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst)          timeout <= 1'b0;
    else if (give_up) timeout <= 1'b1;
    else if (clr)     timeout <= 1'b0;
  end
endmodule

// File: rtl/link_reset_watchdog.sv
module link_reset_watchdog #(
  parameter int INTERVAL_CYCLES = 625_000_000,
  parameter int POLL_CYCLES     = 125,
  parameter int MAX_POLLS       = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic loopback_active,
  input  logic rst_done,
  input  logic tmo_clr,
  output logic logic_rst_pulse,
  output logic timeout_flag
);
  logic hold;
  logic hs_busy;
  logic fire;

  assign hold = link_up || loopback_active;

  lrw_interval_timer #(
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .busy (hs_busy),
    .fire (fire)
  );

  lrw_reset_handshake #(
    .POLL_CYCLES(POLL_CYCLES),
    .MAX_POLLS  (MAX_POLLS)
  ) u_hs (
    .clk     (clk),
    .rst     (rst),
    .start   (fire),
    .done    (rst_done),
    .clr     (tmo_clr),
    .busy    (hs_busy),
    .timeout (timeout_flag)
  );

  assign logic_rst_pulse = fire;
endmodule

// File: rtl/link_reset_watchdog_chk.sv
module link_reset_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic link_up,
  input logic loopback_active,
  input logic tmo_clr,
  input logic logic_rst_pulse,
  input logic timeout_flag,
  input logic hs_busy
);
  // R1: request lasts one cycle
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (rst)
    logic_rst_pulse |=> !logic_rst_pulse) else $error("a_r1_single_cycle");

  // R2 / R3: an edge that sees link up or loopback yields no request
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (link_up || loopback_active) |=> !logic_rst_pulse) else $error("a_r3_hold_blocks");

  // R5: every request starts a handshake
  a_r5_handshake_starts: assert property (@(posedge clk) disable iff (rst)
    logic_rst_pulse |=> hs_busy) else $error("a_r5_handshake_starts");

  // R4 / R8: no new request while a handshake is outstanding
  a_r8_no_req_in_hs: assert property (@(posedge clk) disable iff (rst)
    hs_busy |-> !logic_rst_pulse) else $error("a_r8_no_req_in_hs");

  // R6: the timeout flag only rises as a handshake ends
  a_r6_tmo_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> $fell(hs_busy)) else $error("a_r6_tmo_at_end");

  // R7: the flag is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !tmo_clr) |=> timeout_flag) else $error("a_r7_sticky");

  // R9: reset clears the outputs
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!logic_rst_pulse && !timeout_flag)) else $error("a_r9_reset_state");
endmodule

bind link_reset_watchdog link_reset_watchdog_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .link_up         (link_up),
  .loopback_active (loopback_active),
  .tmo_clr         (tmo_clr),
  .logic_rst_pulse (logic_rst_pulse),
  .timeout_flag    (timeout_flag),
  .hs_busy         (hs_busy)
);

// File: tb/link_reset_watchdog_test.sv
module link_reset_watchdog_test;
  localparam int IC = 20;
  localparam int PC = 3;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b1;
  logic loopback_active = 1'b0;
  logic rst_done = 1'b0;
  logic tmo_clr = 1'b0;
  logic logic_rst_pulse;
  logic timeout_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int done_delay = -1;
  int since = 0;

  always #4 clk = ~clk;

  link_reset_watchdog #(
    .INTERVAL_CYCLES(IC),
    .POLL_CYCLES    (PC),
    .MAX_POLLS      (MP)
  ) uut (
    .clk             (clk),
    .rst             (rst),
    .link_up         (link_up),
    .loopback_active (loopback_active),
    .rst_done        (rst_done),
    .tmo_clr         (tmo_clr),
    .logic_rst_pulse (logic_rst_pulse),
    .timeout_flag    (timeout_flag)
  );

  // Responder: the reset bit reads clear done_delay cycles after the request.
  always @(negedge clk) begin
    if (logic_rst_pulse) since = 0;
    else                 since = since + 1;
    rst_done = (done_delay >= 0) && (since >= done_delay);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (logic_rst_pulse) break;
      if (n > limit) begin
        n = -1;
        break;
      end
    end
  endtask

  task automatic quiet(input int cycles, input string tag);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (logic_rst_pulse) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int n;
    int g;
    int j;
    int eg;
    bit tmo;

    // R9: reset state
    link_up = 1'b0;
    repeat (3) @(negedge clk);
    chk(logic_rst_pulse == 1'b0, "R9 pulse in reset", logic_rst_pulse, 0);
    chk(timeout_flag == 1'b0, "R9 flag in reset", timeout_flag, 0);
    rst = 1'b0;
    done_delay = 0;
    // R9: the timer starts from zero, so the first request lands exactly one interval later
    wait_pulse(IC + 2, n);
    chk(n == IC, "R9/R1 first interval after reset", n, IC);
    @(negedge clk);
    chk(logic_rst_pulse == 1'b0, "R1 pulse width", logic_rst_pulse, 0);
    link_up = 1'b1;
    quiet(IC + PC + 4, "R2 link up no request");

    // R4 R5 R6: sweep the responder delay across all poll instants
    for (int k = 0; k <= MP * PC + 2; k++) begin
      done_delay = k;
      link_up = 1'b0;
      wait_pulse(IC + 2, n);
      chk(n == IC, "R1 interval", n, IC);
      wait_pulse(3 * IC + MP * PC, g);
      j = (k <= PC) ? 1 : (k + PC - 1) / PC;
      tmo = (j > MP);
      eg = tmo ? (1 + MP * PC + IC) : (1 + j * PC + IC);
      chk(g == eg, tmo ? "R6 gap after timeout" : "R5 gap after done", g, eg);
      chk(timeout_flag == tmo, "R6 timeout flag", timeout_flag, int'(tmo));
      link_up = 1'b1;
      quiet(MP * PC + IC + 4, "R4 no request after link up");
      tmo_clr = 1'b1;
      @(negedge clk);
      tmo_clr = 1'b0;
      chk(timeout_flag == 1'b0, "R7 write-one clear", timeout_flag, 0);
    end

    // R2: one up cycle just before expiry restarts the count
    done_delay = 0;
    link_up = 1'b0;
    repeat (IC - 2) @(negedge clk);
    link_up = 1'b1;
    @(negedge clk);
    link_up = 1'b0;
    wait_pulse(IC + 2, n);
    chk(n == IC, "R2 restart on link up", n, IC);
    link_up = 1'b1;
    quiet(IC + PC + 4, "R2 settle");

    // R3: loopback suppresses requests with link down
    loopback_active = 1'b1;
    link_up = 1'b0;
    quiet(3 * IC, "R3 loopback suppresses");
    loopback_active = 1'b0;
    wait_pulse(IC + 2, n);
    chk(n == IC, "R3 timing after loopback", n, IC);
    link_up = 1'b1;
    quiet(IC + PC + 4, "R3 settle");

    // R8: link up during a handshake does not abort it
    done_delay = -1;
    link_up = 1'b0;
    wait_pulse(IC + 2, n);
    link_up = 1'b1;
    repeat (MP * PC) @(negedge clk);
    chk(timeout_flag == 1'b0, "R8 flag before last poll", timeout_flag, 0);
    @(negedge clk);
    chk(timeout_flag == 1'b1, "R8 timeout despite link up", timeout_flag, 1);
    quiet(IC + 4, "R8 no request after");

    // R7: set wins over a clear on the same edge
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
    link_up = 1'b0;
    wait_pulse(IC + 2, n);
    tmo_clr = 1'b1;
    repeat (MP * PC + 1) @(negedge clk);
    chk(timeout_flag == 1'b1, "R7 set wins over clear", timeout_flag, 1);
    @(negedge clk);
    chk(timeout_flag == 1'b0, "R7 clear next cycle", timeout_flag, 0);
    tmo_clr = 1'b0;
    link_up = 1'b1;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule